// File: doc/BRIEF.md
# Serially Configured Programmable Logic Array

This block is a sum-of-products logic array whose whole personality is set at run time. It has a set number of inputs, outputs and product terms. A configuration word is shifted in one fuse per clock on a load port. A restart strobe puts the loader back at the first fuse. Once the last fuse has been taken, the array turns any presented input word into an output word combinationally, in the same cycle.

The fuses fill three stores. The first holds, for each term, the literal masks that select inputs in true or inverted form. The second holds, for each term, the set of outputs that the term drives. The third holds one inversion bit per output. Input bit positions that the `VALID_MASK` parameter leaves out never take part in any product. Two parameter sets are meant to be used: 16 inputs, 8 outputs and 48 terms; and 27 inputs, 18 outputs and 48 terms. Up to 512 terms are allowed.

Top module: `pla_array`

## Requirements
- R1: Fuses arrive term by term, starting at term 0. Within a term, each input in ascending index order takes two fuses: first the inverted-literal fuse, then the true-literal fuse. These are followed by one connection fuse per output, in ascending order.
- R2: A connection fuse of 0 links the term to that output. A connection fuse of 1 leaves the term unlinked.
- R3: After the last term, one inversion fuse per output follows, in ascending order. The output word is the OR of the connection masks of all active terms, XORed with these inversion bits.
- R4: A term is active when, at every considered input bit i, (true fuse OR in[i]) AND (inverted fuse OR NOT in[i]) is 1. A true fuse of 0 requires in[i]=1. An inverted fuse of 0 requires in[i]=0. Both fuses at 1 drop input i from the term.
- R5: An input bit whose position is 0 in `VALID_MASK` has no effect on any output.
- R6: When no term is active, the output word equals the inversion bits.
- R7: `map_ready` rises in the cycle after exactly T*(2N+M)+M accepted fuses, where N is the input count, M the output count and T the term count. Fuses offered after that are ignored until the next restart.
- R8: After reset, and whenever `map_ready` is 0, every output bit is 1.
- R9: `map_start` clears `map_ready` and returns loading to the first fuse. A fuse offered in the same cycle as `map_start` is dropped.
- R10: A term with both fuses 0 on any considered input is never active. A term with all of its input fuses at 1 is always active.
- R11: A fuse is taken only in a cycle where `fuse_vld` is 1. The value on `fuse_bit` is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_start | input | 1 | Restart the fuse load at the first fuse |
| fuse_vld | input | 1 | `fuse_bit` carries a fuse this cycle |
| fuse_bit | input | 1 | Serial fuse value |
| in_word | input | N_IN | Input word to evaluate |
| map_ready | output | 1 | All fuses loaded |
| out_word | output | N_OUT | Evaluated output word |

## Verification
The fuse loader is registered: a fuse offered in one cycle is stored at the following rising edge. `map_ready` therefore rises at the same edge that takes the final fuse, and the bench checks it at the next falling edge. Just before sending the last fuse, the bench also confirms that `map_ready` is still 0 and the outputs are still all ones. The evaluation path has no register, so `out_word` is due in the same cycle as `in_word`. The bench drives each input word at a falling edge and samples a moment later, well before the next rising edge. Restarts, ignored strobes and surplus fuses are each followed by an evaluation of a known word, so that any disturbed fuse shows up at the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    K_INV  = 2'd0,
    K_TRUE = 2'd1,
    K_CONN = 2'd2,
    K_POL  = 2'd3
  } fuse_kind_e;

  typedef enum logic [1:0] {
    LD_TERMS = 2'd0,
    LD_POL   = 2'd1,
    LD_DONE  = 2'd2
  } load_state_e;

  function automatic int fuse_total(input int n_in, input int n_out, input int n_term);
    return n_term * (2 * n_in + n_out) + n_out;
  endfunction

endpackage

// File: rtl/pla_fuse_loader.sv
module pla_fuse_loader
  import pla_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 8,
  parameter int N_TERM = 48,
  localparam int ROW   = 2 * N_IN + N_OUT,
  localparam int PW    = $clog2(ROW),
  localparam int TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_start,
  input  logic             fuse_vld,
  input  logic             fuse_bit,
  output logic             wr_en,
  output fuse_kind_e       wr_kind,
  output logic [TW-1:0]    wr_term,
  output logic [PW-1:0]    wr_idx,
  output logic             wr_val,
  output logic             ready
);

  load_state_e     st_q, st_d;
  logic [PW-1:0]   pos_q, pos_d;
  logic [TW-1:0]   term_q, term_d;
  logic            take;
  logic            upd_en;

  assign take    = fuse_vld && !map_start && (st_q != LD_DONE);
  assign upd_en  = map_start || take;
  assign wr_en   = take;
  assign wr_val  = fuse_bit;
  assign wr_term = term_q;
  assign ready   = (st_q == LD_DONE);

  always_comb begin
    wr_kind = K_POL;
    wr_idx  = pos_q;
    if (st_q == LD_TERMS) begin
      if (pos_q < PW'(2 * N_IN)) begin
        wr_kind = pos_q[0] ? K_TRUE : K_INV;
        wr_idx  = pos_q >> 1;
      end else begin
        wr_kind = K_CONN;
        wr_idx  = pos_q - PW'(2 * N_IN);
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    term_d = term_q;
    if (map_start) begin
      st_d   = LD_TERMS;
      pos_d  = '0;
      term_d = '0;
    end else if (take) begin
      if (st_q == LD_TERMS) begin
        if (pos_q == PW'(ROW - 1)) begin
          pos_d = '0;
          if (term_q == TW'(N_TERM - 1)) begin
            term_d = '0;
            st_d   = LD_POL;
          end else begin
            term_d = term_q + 1'b1;
          end
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end else begin
        if (pos_q == PW'(N_OUT - 1)) begin
          pos_d = '0;
          st_d  = LD_DONE;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_TERMS;
      pos_q  <= '0;
      term_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      term_q <= term_d;
    end
  end

  p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < PW'(ROW));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    map_start |=> !ready);

  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !map_start) |=> ready);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fuse_vld && !map_start) |=> ($stable(pos_q) && $stable(term_q) && $stable(st_q)));

endmodule

// File: rtl/pla_plane_store.sv
module pla_plane_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 8,
  parameter int N_TERM = 48,
  localparam int ROW   = 2 * N_IN + N_OUT,
  localparam int PW    = $clog2(ROW),
  localparam int TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1,
  localparam int NIW   = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int MIW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  fuse_kind_e                     wr_kind,
  input  logic [TW-1:0]                  wr_term,
  input  logic [PW-1:0]                  wr_idx,
  input  logic                           wr_val,
  output logic [N_TERM-1:0][N_IN-1:0]    lit_true,
  output logic [N_TERM-1:0][N_IN-1:0]    lit_inv,
  output logic [N_TERM-1:0][N_OUT-1:0]   conn,
  output logic [N_OUT-1:0]               pol
);

  logic [NIW-1:0] in_ix;
  logic [MIW-1:0] out_ix;

  assign in_ix  = wr_idx[NIW-1:0];
  assign out_ix = wr_idx[MIW-1:0];

  // Configuration storage carries no reset: out_word is held at all ones
  // until a complete map has been written.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_kind)
        K_INV:   lit_inv[wr_term][in_ix]  <= wr_val;
        K_TRUE:  lit_true[wr_term][in_ix] <= wr_val;
        K_CONN:  conn[wr_term][out_ix]    <= !wr_val;
        default: pol[out_ix]              <= wr_val;
      endcase
    end
  end

endmodule

// File: rtl/pla_eval.sv
module pla_eval #(
  parameter int              N_IN       = 16,
  parameter int              N_OUT      = 8,
  parameter int              N_TERM     = 48,
  parameter logic [N_IN-1:0] VALID_MASK = '1
) (
  input  logic [N_IN-1:0]                in_word,
  input  logic                           ready,
  input  logic [N_TERM-1:0][N_IN-1:0]    lit_true,
  input  logic [N_TERM-1:0][N_IN-1:0]    lit_inv,
  input  logic [N_TERM-1:0][N_OUT-1:0]   conn,
  input  logic [N_OUT-1:0]               pol,
  output logic [N_TERM-1:0]              hit,
  output logic [N_OUT-1:0]               out_word
);

  logic [N_OUT-1:0] sum;

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    assign hit[k] = &(((lit_true[k] | in_word) & (lit_inv[k] | ~in_word)) | ~VALID_MASK);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < N_TERM; k++) begin
      if (hit[k]) sum = sum | conn[k];
    end
  end

  assign out_word = ready ? (sum ^ pol) : '1;

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int              N_IN       = 16,
  parameter int              N_OUT      = 8,
  parameter int              N_TERM     = 48,
  parameter logic [N_IN-1:0] VALID_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_start,
  input  logic             fuse_vld,
  input  logic             fuse_bit,
  input  logic [N_IN-1:0]  in_word,
  output logic             map_ready,
  output logic [N_OUT-1:0] out_word
);

  localparam int ROW = 2 * N_IN + N_OUT;
  localparam int PW  = $clog2(ROW);
  localparam int TW  = (N_TERM > 1) ? $clog2(N_TERM) : 1;

  logic                         wr_en;
  fuse_kind_e                   wr_kind;
  logic [TW-1:0]                wr_term;
  logic [PW-1:0]                wr_idx;
  logic                         wr_val;
  logic [N_TERM-1:0][N_IN-1:0]  lit_true;
  logic [N_TERM-1:0][N_IN-1:0]  lit_inv;
  logic [N_TERM-1:0][N_OUT-1:0] conn;
  logic [N_OUT-1:0]             pol;
  logic [N_TERM-1:0]            hit;

  pla_fuse_loader #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) i_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_start (map_start),
    .fuse_vld  (fuse_vld),
    .fuse_bit  (fuse_bit),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .wr_term   (wr_term),
    .wr_idx    (wr_idx),
    .wr_val    (wr_val),
    .ready     (map_ready)
  );

  pla_plane_store #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) i_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_term  (wr_term),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val),
    .lit_true (lit_true),
    .lit_inv  (lit_inv),
    .conn     (conn),
    .pol      (pol)
  );

  pla_eval #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM), .VALID_MASK(VALID_MASK)) i_eval (
    .in_word  (in_word),
    .ready    (map_ready),
    .lit_true (lit_true),
    .lit_inv  (lit_inv),
    .conn     (conn),
    .pol      (pol),
    .hit      (hit),
    .out_word (out_word)
  );

  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_ready |-> (out_word == '1));

  p_no_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (map_ready && (hit == '0)) |-> (out_word == pol));

  p_no_write_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_ready |-> !wr_en);

endmodule

// File: tb/test_pla_array.sv
module test_pla_array;

  localparam int NI    = 16;
  localparam int NO    = 8;
  localparam int NT    = 8;
  localparam logic [NI-1:0] VMASK = 16'hBFFF;
  localparam int ROWB  = 2 * NI + NO;
  localparam int TOTAL = NT * ROWB + NO;

  // Directed map vectors: {input word, expected output word}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0000, 8'h50}, {16'h0001, 8'h51}, {16'h0002, 8'h56}, {16'h0006, 8'h50},
    {16'h0008, 8'h58}, {16'h8000, 8'h70}, {16'h4000, 8'h50}, {16'hFFFF, 8'h79},
    {16'h800B, 8'h7F}, {16'h0010, 8'h50}
  };

  logic          clk;
  logic          rst_n;
  logic          map_start;
  logic          fuse_vld;
  logic          fuse_bit;
  logic [NI-1:0] in_word;
  logic          map_ready;
  logic [NO-1:0] out_word;

  int n_chk;
  int n_bad;
  bit wd_hit;

  logic [NI-1:0] m_inv  [NT];
  logic [NI-1:0] m_true [NT];
  logic [NO-1:0] m_conn [NT];
  logic [NO-1:0] m_pol;
  logic          stream [TOTAL];

  pla_array #(.N_IN(NI), .N_OUT(NO), .N_TERM(NT), .VALID_MASK(VMASK)) i_pla_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_start (map_start),
    .fuse_vld  (fuse_vld),
    .fuse_bit  (fuse_bit),
    .in_word   (in_word),
    .map_ready (map_ready),
    .out_word  (out_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] ref_eval(input logic [NI-1:0] x);
    logic [NO-1:0] s;
    logic          on;
    s = '0;
    for (int k = 0; k < NT; k++) begin
      on = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (VMASK[i]) begin
          if (!m_true[k][i] && !x[i]) on = 1'b0;
          if (!m_inv[k][i]  &&  x[i]) on = 1'b0;
        end
      end
      if (on) s = s | m_conn[k];
    end
    return s ^ m_pol;
  endfunction

  // Fuse order of R1/R2/R3: inverted then true per input, inverted connection fuses, polarity.
  task automatic build_stream();
    int n;
    n = 0;
    for (int k = 0; k < NT; k++) begin
      for (int i = 0; i < NI; i++) begin
        stream[n] = m_inv[k][i];  n++;
        stream[n] = m_true[k][i]; n++;
      end
      for (int o = 0; o < NO; o++) begin
        stream[n] = !m_conn[k][o]; n++;
      end
    end
    for (int o = 0; o < NO; o++) begin
      stream[n] = m_pol[o]; n++;
    end
  endtask

  // Literal helpers: require 1, require 0, don't care, impossible.
  task automatic set_lit(input int k, input int i, input logic c, input logic t);
    m_inv[k][i]  = c;
    m_true[k][i] = t;
  endtask

  task automatic directed_map();
    for (int k = 0; k < NT; k++) begin
      m_inv[k] = '1; m_true[k] = '1; m_conn[k] = '0;
    end
    set_lit(0, 0, 1'b1, 1'b0);  m_conn[0] = 8'h01;
    set_lit(1, 1, 1'b1, 1'b0);  set_lit(1, 2, 1'b0, 1'b1); m_conn[1] = 8'h06;
    set_lit(2, 3, 1'b1, 1'b0);  m_conn[2] = 8'h08;
    set_lit(3, 4, 1'b0, 1'b0);  m_conn[3] = 8'h80;
    m_conn[4] = 8'h40;
    for (int k = 5; k < NT; k++) begin
      set_lit(k, 15, 1'b1, 1'b0); set_lit(k, 14, 1'b1, 1'b0); m_conn[k] = 8'h20;
    end
    m_pol = 8'h10;
  endtask

  task automatic random_map();
    int r;
    for (int k = 0; k < NT; k++) begin
      for (int i = 0; i < NI; i++) begin
        r = $urandom % 8;
        case (r)
          0: set_lit(k, i, 1'b0, 1'b0);
          1: set_lit(k, i, 1'b0, 1'b1);
          2: set_lit(k, i, 1'b1, 1'b0);
          default: set_lit(k, i, 1'b1, 1'b1);
        endcase
      end
      m_conn[k] = NO'($urandom);
    end
    m_pol = NO'($urandom);
  endtask

  // Sends stream[0..cnt-1]; starts and ends on a falling edge.
  task automatic send(input int cnt, input bit gaps, input bit check_edge);
    for (int n = 0; n < cnt; n++) begin
      if (check_edge && n == TOTAL - 1) begin
        chk("R7 ready before last fuse", 32'(map_ready), 32'd0);
        chk("R8 blank before last fuse", 32'(out_word), 32'hFF);
      end
      if (gaps && (n % 3 == 1)) begin
        fuse_vld = 1'b0;
        fuse_bit = !stream[n];
        @(negedge clk);
      end
      fuse_vld = 1'b1;
      fuse_bit = stream[n];
      @(negedge clk);
      fuse_vld = 1'b0;
    end
  endtask

  task automatic restart(input bit with_bit);
    map_start = 1'b1;
    fuse_vld  = with_bit;
    fuse_bit  = 1'b0;
    @(negedge clk);
    map_start = 1'b0;
    fuse_vld  = 1'b0;
  endtask

  task automatic walk_table(input string req);
    for (int v = 0; v < NV; v++) begin
      in_word = VEC[v][23:8];
      #1;
      chk(req, 32'(out_word), 32'(VEC[v][7:0]));
      @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; wd_hit = 1'b0;
    rst_n = 1'b0; map_start = 1'b0; fuse_vld = 1'b0; fuse_bit = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset ready", 32'(map_ready), 32'd0);
    chk("R8 reset out", 32'(out_word), 32'hFF);

    // Directed map with idle strobes carrying wrong bits (R11)
    directed_map();
    build_stream();
    send(TOTAL, 1'b1, 1'b1);
    chk("R7 ready after last fuse", 32'(map_ready), 32'd1);
    walk_table("R1 R2 R3 R4 R5 R6 R10 R11 directed");

    // Surplus fuses after completion (R7)
    for (int n = 0; n < 24; n++) stream[n] = 1'b0;
    send(24, 1'b0, 1'b0);
    in_word = 16'hFFFF; #1;
    chk("R7 surplus ignored", 32'(out_word), 32'h79);
    @(negedge clk);

    // Restart with a fuse on the same edge, then random map (R9)
    restart(1'b1);
    chk("R9 restart clears ready", 32'(map_ready), 32'd0);
    chk("R9 restart blanks out", 32'(out_word), 32'hFF);
    random_map();
    build_stream();
    send(TOTAL, 1'b0, 1'b1);
    chk("R9 ready after full reload", 32'(map_ready), 32'd1);
    for (int j = 0; j < 200; j++) begin
      in_word = NI'($urandom);
      #1;
      chk("R1 R3 R4 random map", 32'(out_word), 32'(ref_eval(in_word)));
      @(negedge clk);
    end

    // Abandon a partial load, restart, reload the directed map (R9)
    random_map();
    build_stream();
    send(100, 1'b0, 1'b0);
    restart(1'b0);
    directed_map();
    build_stream();
    send(TOTAL, 1'b0, 1'b1);
    chk("R9 ready after abandoned load", 32'(map_ready), 32'd1);
    walk_table("R9 directed after restart");

    // Reset mid-operation blanks outputs (R8)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    in_word = 16'h0000; #1;
    chk("R8 out after second reset", 32'(out_word), 32'hFF);

    if (!wd_hit) begin
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule